// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host-side master for a 12-bit successive-approximation converter with a three-wire serial port. The converter runs in the mode where the host's serial clock drives the conversion. A single-cycle start request makes the controller pull the active-low select down while the serial clock is low. It then holds the clock low for a programmable wake-up time and issues exactly sixteen clock periods, idling low and sampling the returned data on each rising edge. It raises select again on the sixteenth falling edge and keeps select high for a programmable minimum gap before it will begin another frame.

The sixteen received bits form a word whose three top bits must all be one. Bit 12 carries the channel tag and bits 11 down to 0 carry the sample, most significant bit first. The controller presents the sample, the channel tag and a framing-error flag together with a one-cycle valid strobe. A request that arrives while a frame or the gap is in progress is remembered and served as soon as the gap ends. The serial clock half-period, the wake-up time and the gap are all counted in system clock cycles and set by parameters.

Top module: `sadc_reader`

## Requirements
- R1: While reset is active, and until a start is seen, select is high, the serial clock is low and valid is low.
- R2: A start seen while idle makes select fall on the next cycle with the serial clock low. The first rising clock edge follows exactly WAKE_CYC + HALF_CYC system cycles after select falls.
- R3: Each frame has exactly sixteen serial clock periods, each made of HALF_CYC cycles low followed by HALF_CYC cycles high. The clock idles low.
- R4: Each received bit is the data input value in the last system cycle before a rising serial clock edge. The first bit received is word bit 15 and the last is word bit 0.
- R5: Select rises in the same cycle as the sixteenth falling serial clock edge. The serial clock is never high while select is high.
- R6: When select rises, valid is high for exactly one cycle, with the result equal to word bits 11:0 and the channel output equal to word bit 12.
- R7: The framing-error output, updated with valid, is 1 when any of word bits 15, 14 or 13 is 0, and 0 when all three are 1.
- R8: Between two frames, select stays high for at least GAP_CYC + 1 system cycles.
- R9: A start that arrives while a frame or gap is in progress is held, and the next frame begins with select falling exactly GAP_CYC + 1 cycles after select rose. Several starts during one frame and its gap yield a single extra frame.
- R10: The result, channel and framing-error outputs keep their values in every cycle in which valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request for one conversion-and-read frame |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low select to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| result_o | output | DATA_W | Received sample, bits 11:0 of the word |
| chan_o | output | 1 | Channel tag, bit 12 of the word |
| ferr_o | output | 1 | Framing error: prefix not all ones |
| valid_o | output | 1 | One-cycle strobe marking new outputs |

## Verification
The embedded properties check the relations that must hold in every cycle. Select falls only with the clock low, the clock is never high while select is high, and select stays high for more than one cycle after it rises. Valid lasts one cycle and coincides with select rising, and the outputs stay stable between strobes. Exact wake-up and half-period lengths, the bit order of capture, prefix decoding and the serving of held requests depend on cycle counts and data. Only the bench scenarios show these, through the reference timeline and the converter model that feeds known words.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAKE  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } sadc_state_e;

endpackage

// File: rtl/sadc_rst_sync.sv
module sadc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int HALF_CYC = 25,
  parameter int WAKE_CYC = 250,
  parameter int GAP_CYC  = 6,
  parameter int FRAME_W  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic cs_n_o,
  output logic sclk_o,
  output logic cap_o,
  output logic done_o
);

  localparam int MAX_HW = (HALF_CYC > WAKE_CYC) ? HALF_CYC : WAKE_CYC;
  localparam int MAX_C  = (MAX_HW > GAP_CYC) ? MAX_HW : GAP_CYC;
  localparam int CW     = $clog2(MAX_C + 1);
  localparam int BW     = $clog2(FRAME_W);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CYC - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_W - 1);

  sadc_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          ph_q, ph_d;
  logic          req_q, req_d;
  logic          cs_n_q, sclk_q;
  logic          cap, done;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    ph_d    = ph_q;
    req_d   = req_q;
    cap     = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i || req_q) begin
          state_d = ST_WAKE;
          cnt_d   = '0;
          req_d   = 1'b0;
        end
      end
      ST_WAKE: begin
        req_d = req_q | start_i;
        if (cnt_q == WAKE_LAST) begin
          state_d = ST_SHIFT;
          cnt_d   = '0;
          bit_d   = '0;
          ph_d    = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        req_d = req_q | start_i;
        if (cnt_q == HALF_LAST) begin
          cnt_d = '0;
          if (!ph_q) begin
            ph_d = 1'b1;
            cap  = 1'b1;
          end else begin
            ph_d = 1'b0;
            if (bit_q == BIT_LAST) begin
              done    = 1'b1;
              state_d = ST_GAP;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        req_d = req_q | start_i;
        if (cnt_q == GAP_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      ph_q    <= 1'b0;
      req_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      ph_q    <= ph_d;
      req_q   <= req_d;
      cs_n_q  <= !((state_d == ST_WAKE) || (state_d == ST_SHIFT));
      sclk_q  <= ph_d;
    end
  end

  assign cs_n_o = cs_n_q;
  assign sclk_o = sclk_q;
  assign cap_o  = cap;
  assign done_o = done;

  // R2
  sel_fall_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> !sclk_q);

  // R5
  no_clk_while_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> !cs_n_q);

  // R8
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |=> cs_n_q);

endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic              sdi_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] result_o,
  output logic              chan_o,
  output logic              ferr_o,
  output logic              valid_o
);

  localparam int PREFIX_W = FRAME_W - DATA_W - 1;
  localparam int CHAN_POS = DATA_W;

  logic [FRAME_W-1:0]  sh_q, sh_d;
  logic [PREFIX_W-1:0] pre_bits;
  logic [DATA_W-1:0]   result_q;
  logic                chan_q, ferr_q, valid_q;
  logic                ferr_d;

  genvar gi;
  generate
    for (gi = 0; gi < PREFIX_W; gi++) begin : g_prefix
      assign pre_bits[gi] = sh_q[FRAME_W-1-gi];
    end
  endgenerate

  always_comb begin
    sh_d   = {sh_q[FRAME_W-2:0], sdi_i};
    ferr_d = ~(&pre_bits);
  end

  // shift register, enabled by the rising-edge strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (cap_i) begin
      sh_q <= sh_d;
    end
  end

  // output registers, enabled at frame end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      chan_q   <= 1'b0;
      ferr_q   <= 1'b0;
    end else if (done_i) begin
      result_q <= sh_q[DATA_W-1:0];
      chan_q   <= sh_q[CHAN_POS];
      ferr_q   <= ferr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= done_i;
    end
  end

  assign result_o = result_q;
  assign chan_o   = chan_q;
  assign ferr_o   = ferr_q;
  assign valid_o  = valid_q;

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R10
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(result_q) && $stable(chan_q) && $stable(ferr_q)));

endmodule

// File: rtl/sadc_reader.sv
module sadc_reader #(
  parameter int HALF_CYC = 25,
  parameter int WAKE_CYC = 250,
  parameter int GAP_CYC  = 6,
  parameter int FRAME_W  = 16,
  parameter int DATA_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sdi_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] result_o,
  output logic              chan_o,
  output logic              ferr_o,
  output logic              valid_o
);

  logic rst_n_s;
  logic cap, done;

  sadc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  sadc_seq #(
    .HALF_CYC (HALF_CYC),
    .WAKE_CYC (WAKE_CYC),
    .GAP_CYC  (GAP_CYC),
    .FRAME_W  (FRAME_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start_i (start_i),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .cap_o   (cap),
    .done_o  (done)
  );

  sadc_capture #(
    .FRAME_W (FRAME_W),
    .DATA_W  (DATA_W)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cap_i    (cap),
    .sdi_i    (sdi_i),
    .done_i   (done),
    .result_o (result_o),
    .chan_o   (chan_o),
    .ferr_o   (ferr_o),
    .valid_o  (valid_o)
  );

  // R6
  valid_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    valid_o |-> $rose(cs_n_o));

endmodule

// File: tb/sadc_reader_test.sv
module sadc_reader_test;

  localparam int H  = 2;
  localparam int W  = 5;
  localparam int G  = 3;
  localparam int SE = W + 32 * H;   // cycle index where select rises
  localparam int TE = SE + G;       // index at which the model is idle again

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        sdi_i;
  logic        cs_n_o, sclk_o, chan_o, ferr_o, valid_o;
  logic [11:0] result_o;

  int checks = 0;
  int bad    = 0;
  int cyc    = 0;
  bit run_chk = 0;

  sadc_reader #(.HALF_CYC(H), .WAKE_CYC(W), .GAP_CYC(G), .FRAME_W(16), .DATA_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdi_i(sdi_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .result_o(result_o),
    .chan_o(chan_o), .ferr_o(ferr_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural timeline: m_t = cycles since select fell, -1 when idle
  int m_t   = -1;
  bit m_pend = 0;
  int n_tx  = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = -1;
      m_pend = 0;
    end else if (m_t < 0) begin
      if (start_i || m_pend) begin
        m_t = 0;
        m_pend = 0;
      end
    end else begin
      if (start_i) m_pend = 1;
      m_t++;
      if (m_t == TE) m_t = -1;
    end
  end

  function automatic bit exp_cs_n(int t);
    return !(t >= 0 && t < SE);
  endfunction
  function automatic bit exp_sclk(int t);
    return (t >= W) && (t < SE) && (((t - W) % (2 * H)) >= H);
  endfunction

  // converter model and observation
  logic [15:0] words_q[$];
  logic [15:0] exp_q[$];
  logic [15:0] fe_word = 16'h0;
  int          fe_idx = -1;
  bit          prev_cs = 1, prev_sclk = 0;
  int          hi_cnt = 0, low_cnt = 0;
  bit          seen_tx = 0, wait_rise = 0;
  logic [11:0] last_res = 12'h0;
  bit          last_chan = 0, last_ferr = 0;

  always @(negedge clk) begin
    cyc++;
    if (run_chk) begin
      chk("R5 select", cs_n_o, exp_cs_n(m_t));
      chk("R3 sclk", sclk_o, exp_sclk(m_t));
      chk("R6 valid", valid_o, (m_t == SE));
      if (valid_o) begin
        logic [15:0] w;
        w = exp_q.size() > 0 ? exp_q.pop_front() : 16'hxxxx;
        chk("R4 R6 result", result_o, w[11:0]);
        chk("R6 chan", chan_o, w[12]);
        chk("R7 ferr", ferr_o, !(w[15] & w[14] & w[13]));
        last_res = w[11:0]; last_chan = w[12]; last_ferr = !(w[15] & w[14] & w[13]);
      end else begin
        chk("R10 hold", {ferr_o, chan_o, result_o}, {last_ferr, last_chan, last_res});
      end
    end
    // R2 wake length and R8 gap length
    if (prev_cs && !cs_n_o) begin
      checks++;
      if (sclk_o) begin bad++; $display("FAIL R2: actual sclk=1 expected 0 at select fall"); end
      if (seen_tx) chk("R8 gap", (hi_cnt >= G + 1), 1);
      seen_tx = 1; wait_rise = 1; low_cnt = 0; n_tx++;
    end
    if (wait_rise) begin
      if (sclk_o) begin chk("R2 first rise", low_cnt, W + H); wait_rise = 0; end
      else low_cnt++;
    end
    hi_cnt = cs_n_o ? hi_cnt + 1 : 0;
    // converter drives data on select fall and on each falling clock
    if (prev_cs && !cs_n_o) begin
      fe_word = words_q.size() > 0 ? words_q.pop_front() : 16'hE000;
      exp_q.push_back(fe_word);
      fe_idx = 15;
    end else if (prev_sclk && !sclk_o && !cs_n_o) begin
      fe_idx--;
    end
    sdi_i = (!cs_n_o && fe_idx >= 0) ? fe_word[fe_idx] : 1'b0;
    prev_cs = cs_n_o;
    prev_sclk = sclk_o;
    if (cyc > 100000) begin
      bad++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (m_t >= 0 || m_pend) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_one(input logic [15:0] w);
    words_q.push_back(w);
    @(negedge clk);
    pulse_start();
    wait_idle();
  endtask

  initial begin
    int base;
    rst_n = 1'b0;
    start_i = 1'b0;
    sdi_i = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 select", cs_n_o, 1);
    chk("R1 sclk", sclk_o, 0);
    chk("R1 valid", valid_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 select after release", cs_n_o, 1);
    run_chk = 1;

    run_one(16'hE5A3);  // channel 0, good prefix
    run_one(16'hFABC);  // channel 1
    run_one(16'hE000);  // zero sample
    run_one(16'hFFFF);  // full scale
    run_one(16'h6123);  // R7 bit 15 clear
    run_one(16'hB456);  // R7 bit 14 clear
    run_one(16'hD789);  // R7 bit 13 clear
    run_one(16'h1555);  // R7 whole prefix clear

    // R9 requests during a frame collapse to one extra frame
    base = n_tx;
    words_q.push_back(16'hE321);
    words_q.push_back(16'hF0F0);
    @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_start();
    wait_idle();
    chk("R9 frame count", n_tx - base, 2);

    // R9 request in the gap
    base = n_tx;
    words_q.push_back(16'hE777);
    words_q.push_back(16'hF888);
    @(negedge clk);
    pulse_start();
    while (cs_n_o == 1'b0) @(negedge clk);
    pulse_start();
    wait_idle();
    chk("R9 gap request", n_tx - base, 2);

    // start held high: back-to-back frames
    base = n_tx;
    words_q.push_back(16'hE9AB);
    words_q.push_back(16'hFCDE);
    start_i = 1'b1;
    while (n_tx - base < 2) @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    chk("R8 R9 held start frames", (n_tx - base >= 2), 1);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule